// File: doc/BRIEF.md
# Asynchronous SRAM Write Sequencer

This block runs write cycles into an external asynchronous static RAM of 128K words by 16 bits. The RAM has two chip-select lines of opposite polarity, separate upper and lower byte-lane enables, and an active-low write enable. A synchronous host presents a request together with a 17-bit word address, 16-bit data, a 2-bit lane mask and a cycle-style select. The sequencer captures these on acceptance and steps the memory pins through setup, strobe, hold and recovery phases. The length of each phase is a whole number of clock cycles and is set by a parameter.

Two write styles are offered. In the strobe-timed style the selects open the cycle and a write-enable pulse defines the write. In the select-timed style write enable goes low first and the chip selects with the lane enables define the write. In both styles the write ends when the first control line is released. Recovery is counted from that release, and a one-clock completion pulse follows the end of recovery.

Top module: `sram_wr_ctrl`

## Requirements
- R1: While reset is applied, and once it is released with no request, the memory side is in standby: `mem_cs_n`=1, `mem_cs`=0, `mem_ub_n`=1, `mem_lb_n`=1, `mem_we_n`=1, `mem_dout_en`=0. Also `host_ready`=1, `host_done`=0 and `mem_addr`=0.
- R2: A request is taken only on a clock edge where `host_ready` is 1. `host_ready` is 0 from the edge that accepts a request until the cycle in which its done pulse is shown. A request raised while busy is ignored: it starts no cycle, changes no pin and adds no done pulse.
- R3: A request accepted at edge k gives `host_done`=1 for exactly the one cycle after edge k+S+P+H+R, where S, P, H and R are the setup, strobe, hold and recovery counts. `host_ready` is 1 in that same cycle.
- R4: Strobe-timed style (`host_cs_mode`=0). During setup the selects are active and `mem_we_n`=1. During strobe `mem_we_n`=0. During hold `mem_we_n`=1 and the selects stay active. During recovery the selects are in standby. `mem_dout_en` is 1 during strobe and hold only.
- R5: Select-timed style (`host_cs_mode`=1). `mem_we_n`=0 during setup, strobe and hold, and 1 during recovery. The selects are active during strobe only. `mem_dout_en` is 1 during setup, strobe and hold.
- R6: The write overlap occurs only during the strobe phase, and `mem_dout_en` is 1 whenever it occurs. The overlap is `mem_we_n`=0, `mem_cs_n`=0, `mem_cs`=1 and at least one lane enable low.
- R7: Mask bit 0 drives the lower lane (`mem_lb_n`). Mask bit 1 drives the upper lane (`mem_ub_n`). A lane enable goes low only while the selects are active and its mask bit is 1.
- R8: A request with mask 00 keeps every memory control pin in standby and `mem_dout_en` at 0. It still finishes with a done pulse at the R3 time.
- R9: `mem_addr` equals the accepted address from the cycle after acceptance until the next request is accepted.
- R10: While `mem_dout_en` is 1, `mem_dout` equals the accepted write data and does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_req | input | 1 | Write request |
| host_addr | input | 17 | Word address |
| host_wdata | input | 16 | Write data |
| host_mask | input | 2 | Lane mask, bit 0 lower byte, bit 1 upper byte |
| host_cs_mode | input | 1 | 0 strobe-timed, 1 select-timed |
| host_ready | output | 1 | Idle, a request is taken on the next edge |
| host_done | output | 1 | One-cycle completion pulse |
| mem_addr | output | 17 | Memory address |
| mem_cs_n | output | 1 | Active-low chip select |
| mem_cs | output | 1 | Active-high chip select |
| mem_ub_n | output | 1 | Active-low upper lane enable |
| mem_lb_n | output | 1 | Active-low lower lane enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_dout | output | 16 | Data toward the memory bus |
| mem_dout_en | output | 1 | Drive enable for the data bus |

## Verification
Every memory pin changes in the cycle right after the clock edge that moves the phase counter, because the pins are decoded from registered state without any further register. A cycle accepted at edge k therefore has setup starting in the cycle after edge k, and the done pulse shows in the cycle after edge k+S+P+H+R. The bench model keeps an integer count of edges since acceptance and derives every expected pin level and the done time from that count. It compares each cycle at the falling edge and drives inputs shortly after the rising edge, so the compared values have settled and the stimulus for the next edge is already stable.

// File: rtl/sram_wr_pkg.sv
package sram_wr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SETUP  = 3'd1,
    ST_STROBE = 3'd2,
    ST_HOLD   = 3'd3,
    ST_RECOV  = 3'd4
  } wr_state_e;

  typedef enum logic {
    MODE_WE = 1'b0,
    MODE_CS = 1'b1
  } wr_mode_e;

endpackage

// File: rtl/sram_wr_fsm.sv
module sram_wr_fsm
  import sram_wr_pkg::*;
#(
  parameter int SETUP_CYC  = 2,
  parameter int STROBE_CYC = 3,
  parameter int HOLD_CYC   = 1,
  parameter int RECOV_CYC  = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start_i,
  output wr_state_e state_o,
  output logic      done_o
);

  localparam int MAX_A = (SETUP_CYC > STROBE_CYC) ? SETUP_CYC : STROBE_CYC;
  localparam int MAX_B = (HOLD_CYC > RECOV_CYC) ? HOLD_CYC : RECOV_CYC;
  localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CW    = $clog2(MAX_C + 1);

  localparam logic [CW-1:0] LD_SETUP  = CW'(SETUP_CYC - 1);
  localparam logic [CW-1:0] LD_STROBE = CW'(STROBE_CYC - 1);
  localparam logic [CW-1:0] LD_HOLD   = CW'(HOLD_CYC - 1);
  localparam logic [CW-1:0] LD_RECOV  = CW'(RECOV_CYC - 1);

  wr_state_e     st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d;
  logic          cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  // next-state logic
  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    done_d = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          st_d  = ST_SETUP;
          cnt_d = LD_SETUP;
        end
      end
      ST_SETUP: begin
        if (cnt_zero) begin
          st_d  = ST_STROBE;
          cnt_d = LD_STROBE;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_STROBE: begin
        if (cnt_zero) begin
          st_d  = ST_HOLD;
          cnt_d = LD_HOLD;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_HOLD: begin
        if (cnt_zero) begin
          st_d  = ST_RECOV;
          cnt_d = LD_RECOV;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_RECOV: begin
        if (cnt_zero) begin
          st_d   = ST_IDLE;
          cnt_d  = '0;
          done_d = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: begin
        st_d  = ST_IDLE;
        cnt_d = '0;
      end
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign state_o = st_q;
  assign done_o  = done_q;

  // R3
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R3
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (st_q == ST_IDLE));

  // R2
  start_only_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_IDLE) |=> (st_q != ST_SETUP) || ($past(st_q) == ST_SETUP));

endmodule

// File: rtl/sram_wr_capture.sv
module sram_wr_capture
  import sram_wr_pkg::*;
#(
  parameter int AW = 17,
  parameter int DW = 16,
  parameter int NB = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  input  logic [NB-1:0] mask_i,
  input  logic          mode_i,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] data_o,
  output logic [NB-1:0] mask_o,
  output wr_mode_e      mode_o
);

  logic [AW-1:0] addr_q, addr_d;
  logic [DW-1:0] data_q, data_d;
  logic [NB-1:0] mask_q, mask_d;
  wr_mode_e      mode_q, mode_d;

  // clock enable for the request fields
  always_comb begin
    addr_d = addr_q;
    data_d = data_q;
    mask_d = mask_q;
    mode_d = mode_q;
    if (load_i) begin
      addr_d = addr_i;
      data_d = data_i;
      mask_d = mask_i;
      mode_d = wr_mode_e'(mode_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
      mask_q <= '0;
      mode_q <= MODE_WE;
    end else begin
      addr_q <= addr_d;
      data_q <= data_d;
      mask_q <= mask_d;
      mode_q <= mode_d;
    end
  end

  assign addr_o = addr_q;
  assign data_o = data_q;
  assign mask_o = mask_q;
  assign mode_o = mode_q;

endmodule

// File: rtl/sram_wr_pins.sv
module sram_wr_pins
  import sram_wr_pkg::*;
#(
  parameter int NB = 2
) (
  input  wr_state_e     state_i,
  input  wr_mode_e      mode_i,
  input  logic [NB-1:0] mask_i,
  output logic          cs_n_o,
  output logic          cs_o,
  output logic [NB-1:0] lane_n_o,
  output logic          we_n_o,
  output logic          dout_en_o
);

  logic any_lane;
  logic in_setup, in_strobe, in_hold;
  logic sel_on, we_on, drv_on;

  assign any_lane  = |mask_i;
  assign in_setup  = (state_i == ST_SETUP);
  assign in_strobe = (state_i == ST_STROBE);
  assign in_hold   = (state_i == ST_HOLD);

  always_comb begin
    sel_on = 1'b0;
    we_on  = 1'b0;
    drv_on = 1'b0;
    if (any_lane) begin
      if (mode_i == MODE_WE) begin
        sel_on = in_setup | in_strobe | in_hold;
        we_on  = in_strobe;
        drv_on = in_strobe | in_hold;
      end else begin
        sel_on = in_strobe;
        we_on  = in_setup | in_strobe | in_hold;
        drv_on = in_setup | in_strobe | in_hold;
      end
    end
  end

  assign cs_n_o    = ~sel_on;
  assign cs_o      = sel_on;
  assign we_n_o    = ~we_on;
  assign dout_en_o = drv_on;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign lane_n_o[g] = ~(sel_on & mask_i[g]);
  end

endmodule

// File: rtl/sram_wr_ctrl.sv
module sram_wr_ctrl
  import sram_wr_pkg::*;
#(
  parameter int AW         = 17,
  parameter int DW         = 16,
  parameter int SETUP_CYC  = 2,
  parameter int STROBE_CYC = 3,
  parameter int HOLD_CYC   = 1,
  parameter int RECOV_CYC  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_req,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  input  logic [1:0]    host_mask,
  input  logic          host_cs_mode,
  output logic          host_ready,
  output logic          host_done,
  output logic [AW-1:0] mem_addr,
  output logic          mem_cs_n,
  output logic          mem_cs,
  output logic          mem_ub_n,
  output logic          mem_lb_n,
  output logic          mem_we_n,
  output logic [DW-1:0] mem_dout,
  output logic          mem_dout_en
);

  localparam int NB = 2;

  logic          rst_meta_q, rst_sync_q;
  wr_state_e     state;
  logic          accept;
  logic [NB-1:0] mask_q;
  wr_mode_e      mode_q;
  logic [NB-1:0] lane_n;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  assign host_ready = (state == ST_IDLE);
  assign accept     = host_req & host_ready;

  sram_wr_fsm #(
    .SETUP_CYC (SETUP_CYC),
    .STROBE_CYC(STROBE_CYC),
    .HOLD_CYC  (HOLD_CYC),
    .RECOV_CYC (RECOV_CYC)
  ) u_fsm (
    .clk    (clk),
    .rst_n  (rst_sync_q),
    .start_i(accept),
    .state_o(state),
    .done_o (host_done)
  );

  sram_wr_capture #(
    .AW(AW),
    .DW(DW),
    .NB(NB)
  ) u_capture (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .load_i(accept),
    .addr_i(host_addr),
    .data_i(host_wdata),
    .mask_i(host_mask),
    .mode_i(host_cs_mode),
    .addr_o(mem_addr),
    .data_o(mem_dout),
    .mask_o(mask_q),
    .mode_o(mode_q)
  );

  sram_wr_pins #(
    .NB(NB)
  ) u_pins (
    .state_i  (state),
    .mode_i   (mode_q),
    .mask_i   (mask_q),
    .cs_n_o   (mem_cs_n),
    .cs_o     (mem_cs),
    .lane_n_o (lane_n),
    .we_n_o   (mem_we_n),
    .dout_en_o(mem_dout_en)
  );

  assign mem_lb_n = lane_n[0];
  assign mem_ub_n = lane_n[1];

  // R6
  overlap_drive_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (!mem_we_n && !mem_cs_n && mem_cs && (!mem_ub_n || !mem_lb_n)) |-> mem_dout_en);

  // R6
  overlap_in_strobe_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (!mem_we_n && !mem_cs_n && mem_cs) |-> (state == ST_STROBE));

  // R9
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (state != ST_IDLE) |=> $stable(mem_addr));

  // R10
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    mem_dout_en |=> (!mem_dout_en || $stable(mem_dout)));

  // R8
  empty_mask_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (mask_q == '0) |-> (mem_we_n && mem_cs_n && !mem_dout_en));

  // R2
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    accept |=> !host_ready);

endmodule

// File: tb/sram_wr_ctrl_tb_top.sv
`timescale 1ns/1ps
module sram_wr_ctrl_tb_top;

  localparam int S = 2;
  localparam int P = 3;
  localparam int H = 1;
  localparam int R = 2;
  localparam int T = S + P + H + R;

  logic        clk;
  logic        rst_n;
  logic        host_req;
  logic [16:0] host_addr;
  logic [15:0] host_wdata;
  logic [1:0]  host_mask;
  logic        host_cs_mode;
  logic        host_ready;
  logic        host_done;
  logic [16:0] mem_addr;
  logic        mem_cs_n, mem_cs, mem_ub_n, mem_lb_n, mem_we_n;
  logic [15:0] mem_dout;
  logic        mem_dout_en;

  int n_checks = 0;
  int n_fails  = 0;
  int cycles   = 0;
  bit finished = 0;

  // reference model state
  bit          m_busy;
  int          m_t;
  bit          m_done;
  logic [16:0] m_addr;
  logic [15:0] m_data;
  logic [1:0]  m_mask;
  bit          m_mode;
  int          exp_dones = 0;
  int          got_dones = 0;

  sram_wr_ctrl #(
    .AW(17), .DW(16),
    .SETUP_CYC(S), .STROBE_CYC(P), .HOLD_CYC(H), .RECOV_CYC(R)
  ) dut_i (
    .clk(clk), .rst_n(rst_n),
    .host_req(host_req), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_mask(host_mask), .host_cs_mode(host_cs_mode),
    .host_ready(host_ready), .host_done(host_done),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_cs(mem_cs),
    .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n), .mem_we_n(mem_we_n),
    .mem_dout(mem_dout), .mem_dout_en(mem_dout_en)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s t=%0t actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  endtask

  // behavioural reference, advanced on each rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_t = 0; m_done = 0;
      m_addr = '0; m_data = '0; m_mask = '0; m_mode = 0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        m_t = m_t + 1;
        if (m_t == T) begin
          m_busy = 0;
          m_done = 1;
          exp_dones++;
        end
      end else if (host_req) begin
        m_busy = 1; m_t = 0;
        m_addr = host_addr; m_data = host_wdata;
        m_mask = host_mask; m_mode = host_cs_mode;
      end
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    bit act, ph_set, ph_stb, ph_hld, sel, we, oe;
    string tag;
    act    = m_busy && (m_mask != 2'b00);
    ph_set = m_busy && (m_t < S);
    ph_stb = m_busy && (m_t >= S) && (m_t < S + P);
    ph_hld = m_busy && (m_t >= S + P) && (m_t < S + P + H);
    if (!m_mode) begin
      sel = act && (ph_set || ph_stb || ph_hld);
      we  = act && ph_stb;
      oe  = act && (ph_stb || ph_hld);
    end else begin
      sel = act && ph_stb;
      we  = act && (ph_set || ph_stb || ph_hld);
      oe  = act && (ph_set || ph_stb || ph_hld);
    end
    if (!m_busy)               tag = "R1 idle pins";
    else if (m_mask == 2'b00)  tag = "R8 empty mask pins";
    else if (ph_stb)           tag = "R6 R7 strobe pins";
    else if (!m_mode)          tag = "R4 strobe-timed pins";
    else                       tag = "R5 select-timed pins";
    chk(tag, {26'd0, mem_cs_n, mem_cs, mem_ub_n, mem_lb_n, mem_we_n, mem_dout_en},
        {26'd0, !sel, sel, !(sel && m_mask[1]), !(sel && m_mask[0]), !we, oe});
    chk("R9 address", {15'd0, mem_addr}, {15'd0, m_addr});
    if (oe) chk("R10 data", {16'd0, mem_dout}, {16'd0, m_data});
    chk("R3 done", {31'd0, host_done}, {31'd0, m_done});
    chk("R2 ready", {31'd0, host_ready}, {31'd0, rst_n ? !m_busy : 1'b1});
    if (host_done) got_dones++;
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      finish_run();
    end
  end

  task automatic idle_cycles(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #2;
  endtask

  task automatic write_req(input logic [16:0] a, input logic [15:0] d,
                           input logic [1:0] m, input bit mode);
    @(posedge clk); #2;
    host_req = 1; host_addr = a; host_wdata = d; host_mask = m; host_cs_mode = mode;
    @(posedge clk); #2;
    host_req = 0;
    idle_cycles(T + 1);
  endtask

  initial begin
    rst_n = 0; host_req = 0; host_addr = '0; host_wdata = '0;
    host_mask = '0; host_cs_mode = 0;
    idle_cycles(3);
    rst_n = 1;
    idle_cycles(4);
    // R4 R7 both lanes, strobe-timed
    write_req(17'h12345, 16'hA5C3, 2'b11, 0);
    // R5 both lanes, select-timed, top address
    write_req(17'h1FFFF, 16'hFFFF, 2'b11, 1);
    // R7 lower lane only, strobe-timed
    write_req(17'h00001, 16'h00FF, 2'b01, 0);
    // R7 upper lane only, select-timed
    write_req(17'h0AAAA, 16'h5A00, 2'b10, 1);
    // R8 empty mask, both styles
    write_req(17'h15555, 16'h1234, 2'b00, 0);
    write_req(17'h02468, 16'h4321, 2'b00, 1);
    // R2 request raised while busy is ignored
    @(posedge clk); #2;
    host_req = 1; host_addr = 17'h00F0F; host_wdata = 16'hC0DE; host_mask = 2'b11; host_cs_mode = 0;
    @(posedge clk); #2;
    host_req = 0;
    idle_cycles(2);
    host_req = 1; host_addr = 17'h1F0F0; host_wdata = 16'hDEAD; host_mask = 2'b10; host_cs_mode = 1;
    @(posedge clk); #2;
    host_req = 0;
    idle_cycles(T + 2);
    // R3 back-to-back requests held high
    host_req = 1; host_addr = 17'h0BEEF; host_wdata = 16'h3C3C; host_mask = 2'b01; host_cs_mode = 1;
    idle_cycles(2 * T + 3);
    host_req = 0;
    idle_cycles(T + 2);
    chk("R2 R3 done count", exp_dones, got_dones);
    chk("R2 ignored request count", got_dones, 32'd10);
    // R1 reset in mid-cycle returns to standby
    write_req(17'h13579, 16'h9BDF, 2'b11, 0);
    @(posedge clk); #2;
    host_req = 1; host_mask = 2'b11;
    @(posedge clk); #2;
    host_req = 0;
    idle_cycles(S);
    rst_n = 0;
    idle_cycles(2);
    rst_n = 1;
    idle_cycles(4);
    finish_run();
  end

endmodule